// File: doc/BRIEF.md
# Inbound Header Credit Partitioner

This block divides a fixed pool of inbound transaction-layer header buffers among three classes of traffic. The posted class covers inbound writes. The non-posted class covers inbound reads and configuration requests. The completion class covers completions that return for reads this core sent out. A configuration write programs the three shares, the limit on outstanding outbound reads and the maximum payload size. The write is taken only if the three shares add up to the pool total. That total is 97 headers, or 259 when the `REV3` parameter is set.

The posted and non-posted shares are presented as the initial credits to advertise to the link partner. Completion credits are always advertised as infinite. Because the link partner is therefore never throttled on completions, the block protects the completion share locally. Each outbound read may return as up to MPS/64 + 1 completions, and that many completion headers are set aside when the read is granted. A read is granted only if both the outstanding-read limit and the completion share leave room for it. A done strobe marks the final completion of a read. It returns the reservation and lowers the outstanding count. Per-class counters follow how many headers of each class sit in the buffer, driven by arrive and release strobes.

Top module: `ib_hdr_credit_part`

## Requirements
- R1: After reset the posted, non-posted and completion shares are 24, 24 and 49. The outstanding-read limit is 8 and the payload code is 0. All counters are zero and `cfg_err` is 0.
- R2: A configuration write is accepted when all three of these hold: posted + non-posted + completion shares equal 97, `cfg_mps` is at most 5, and no read is outstanding. The new settings appear on the outputs in the next cycle and `cfg_err` clears.
- R3: Any other configuration write is rejected. `cfg_err` is 1 in the next cycle and every setting keeps its previous value.
- R4: `adv_p_hdr` and `adv_np_hdr` equal the current posted and non-posted shares. `adv_cpl_hdr` is always 0, which encodes infinite completion credit.
- R5: Bit 0 of `hdr_arrive`/`hdr_release` is posted, bit 1 is non-posted and bit 2 is completion. The class counter moves by +1 on an arrive and by −1 on a release, one cycle later. With both strobes set, the release is applied first, then the arrive.
- R6: An arrive is ignored when the class counter (after any release in the same cycle) is not below the class share. A release is ignored when the counter is 0.
- R7: `cfg_mps` codes 0 to 5 mean 128, 256, 512, 1024, 2048 and 4096 bytes. A granted read reserves MPS/64 + 1 completion headers, that is 3, 5, 9, 17, 33 or 65.
- R8: `rd_gnt` is combinational and equals `rd_req` AND (outstanding < limit) AND (reserved + reservation ≤ completion share) AND NOT `cfg_wr`. A grant raises `rd_outstanding` by 1 and `cpl_reserved` by one reservation in the next cycle.
- R9: `rd_done` lowers `rd_outstanding` by 1 and `cpl_reserved` by one reservation. It is ignored when nothing is outstanding. A grant and a done in the same cycle leave both counts unchanged.
- R10: No read is granted in a cycle where `cfg_wr` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_p_share | input | SH_W | Posted header share |
| cfg_np_share | input | SH_W | Non-posted header share |
| cfg_cpl_share | input | SH_W | Completion header share |
| cfg_max_rd | input | RD_W | Limit on outstanding outbound reads |
| cfg_mps | input | 3 | Maximum payload size code |
| cfg_err | output | 1 | Last configuration write was rejected |
| adv_p_hdr | output | SH_W | Posted initial header credit |
| adv_np_hdr | output | SH_W | Non-posted initial header credit |
| adv_cpl_hdr | output | SH_W | Completion initial credit, 0 = infinite |
| hdr_arrive | input | 3 | Header arrival strobe per class |
| hdr_release | input | 3 | Header release strobe per class |
| hdr_used_p | output | SH_W | Posted headers in use |
| hdr_used_np | output | SH_W | Non-posted headers in use |
| hdr_used_cpl | output | SH_W | Completion headers in use |
| rd_req | input | 1 | Outbound read request |
| rd_gnt | output | 1 | Outbound read grant |
| rd_done | input | 1 | Final completion of a read received |
| rd_outstanding | output | RD_W | Outbound reads in flight |
| cpl_reserved | output | SH_W | Completion headers reserved |

## Verification
The assertions check on every cycle that a grant only happens with a request and no configuration write, and only below the read limit. They also check that the reservation never exceeds the completion share and that an idle read path holds no reservation. In addition they check that a rejected write leaves the shares untouched and that a full class ignores arrivals. Only the bench's scenarios can show that the reservation matches each payload code. The same applies to the exact order of release and arrive in one cycle, to the effect of a reconfiguration on later grants, and to the counts drifting correctly over long random mixes of strobes.

// File: rtl/hcp_pkg.sv
package hcp_pkg;
  localparam int NUM_CLASS = 3;
  localparam int MPS_W     = 3;
  localparam int MPS_CODES = 6;

  // completion headers one read may need: payload/64 + 1, payload = 128 << code
  function automatic logic [7:0] cpl_per_read(logic [MPS_W-1:0] code);
    return 8'((9'd2 << code) + 9'd1);
  endfunction
endpackage

// File: rtl/hcp_cfg_reg.sv
module hcp_cfg_reg
  import hcp_pkg::*;
#(
  parameter bit REV3      = 1'b0,
  parameter int SH_W      = 9,
  parameter int RD_W      = 6,
  parameter int DEF_MAXRD = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [SH_W-1:0]  cfg_p_share,
  input  logic [SH_W-1:0]  cfg_np_share,
  input  logic [SH_W-1:0]  cfg_cpl_share,
  input  logic [RD_W-1:0]  cfg_max_rd,
  input  logic [MPS_W-1:0] cfg_mps,
  input  logic             busy,
  output logic [SH_W-1:0]  p_sh_q,
  output logic [SH_W-1:0]  np_sh_q,
  output logic [SH_W-1:0]  cpl_sh_q,
  output logic [RD_W-1:0]  max_rd_q,
  output logic [MPS_W-1:0] mps_q,
  output logic             err_q
);
  localparam int TOTAL   = REV3 ? 259 : 97;
  localparam int DEF_P   = TOTAL / 4;
  localparam int DEF_CPL = TOTAL - 2 * DEF_P;

  logic [SH_W+1:0]  sum;
  logic             ok;
  logic [SH_W-1:0]  p_d, np_d, cpl_d;
  logic [RD_W-1:0]  max_d;
  logic [MPS_W-1:0] mps_d;
  logic             err_d;

  always_comb begin
    sum   = (SH_W+2)'(cfg_p_share) + (SH_W+2)'(cfg_np_share) + (SH_W+2)'(cfg_cpl_share);
    ok    = (sum == (SH_W+2)'(TOTAL)) && (cfg_mps <= MPS_W'(MPS_CODES-1)) && !busy;
    p_d   = ok ? cfg_p_share   : p_sh_q;
    np_d  = ok ? cfg_np_share  : np_sh_q;
    cpl_d = ok ? cfg_cpl_share : cpl_sh_q;
    max_d = ok ? cfg_max_rd    : max_rd_q;
    mps_d = ok ? cfg_mps       : mps_q;
    err_d = !ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_sh_q   <= SH_W'(DEF_P);
      np_sh_q  <= SH_W'(DEF_P);
      cpl_sh_q <= SH_W'(DEF_CPL);
      max_rd_q <= RD_W'(DEF_MAXRD);
      mps_q    <= '0;
      err_q    <= 1'b0;
    end else if (cfg_wr) begin
      p_sh_q   <= p_d;
      np_sh_q  <= np_d;
      cpl_sh_q <= cpl_d;
      max_rd_q <= max_d;
      mps_q    <= mps_d;
      err_q    <= err_d;
    end
  end
endmodule

// File: rtl/hcp_class_cnt.sv
module hcp_class_cnt #(
  parameter int SH_W = 9
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            arrive,
  input  logic            rel,
  input  logic [SH_W-1:0] limit,
  output logic [SH_W-1:0] count
);
  logic            dec_ok, inc_ok, en;
  logic [SH_W-1:0] after_rel, cnt_d;

  always_comb begin
    dec_ok    = rel && (count != '0);
    after_rel = count - SH_W'(dec_ok);
    inc_ok    = arrive && (after_rel < limit);
    cnt_d     = after_rel + SH_W'(inc_ok);
    en        = dec_ok || inc_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  count <= '0;
    else if (en) count <= cnt_d;
  end
endmodule

// File: rtl/hcp_rd_gate.sv
module hcp_rd_gate
  import hcp_pkg::*;
#(
  parameter int SH_W = 9,
  parameter int RD_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic             done,
  input  logic             blk,
  input  logic [RD_W-1:0]  max_rd,
  input  logic [SH_W-1:0]  cpl_share,
  input  logic [MPS_W-1:0] mps,
  output logic             gnt,
  output logic [RD_W-1:0]  outstanding,
  output logic [SH_W-1:0]  reserved
);
  logic [SH_W:0]   rsv, want;
  logic            done_ok, en;
  logic [RD_W-1:0] out_d;
  logic [SH_W-1:0] res_d;

  always_comb begin
    rsv     = (SH_W+1)'(cpl_per_read(mps));
    want    = {1'b0, reserved} + rsv;
    gnt     = req && !blk && (outstanding < max_rd) && (want <= {1'b0, cpl_share});
    done_ok = done && (outstanding != '0);
    out_d   = outstanding + RD_W'(gnt) - RD_W'(done_ok);
    res_d   = reserved + (gnt ? rsv[SH_W-1:0] : '0) - (done_ok ? rsv[SH_W-1:0] : '0);
    en      = gnt || done_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outstanding <= '0;
      reserved    <= '0;
    end else if (en) begin
      outstanding <= out_d;
      reserved    <= res_d;
    end
  end
endmodule

// File: rtl/ib_hdr_credit_part.sv
module ib_hdr_credit_part
  import hcp_pkg::*;
#(
  parameter bit REV3      = 1'b0,
  parameter int SH_W      = 9,
  parameter int RD_W      = 6,
  parameter int DEF_MAXRD = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [SH_W-1:0]  cfg_p_share,
  input  logic [SH_W-1:0]  cfg_np_share,
  input  logic [SH_W-1:0]  cfg_cpl_share,
  input  logic [RD_W-1:0]  cfg_max_rd,
  input  logic [2:0]       cfg_mps,
  output logic             cfg_err,
  output logic [SH_W-1:0]  adv_p_hdr,
  output logic [SH_W-1:0]  adv_np_hdr,
  output logic [SH_W-1:0]  adv_cpl_hdr,
  input  logic [2:0]       hdr_arrive,
  input  logic [2:0]       hdr_release,
  output logic [SH_W-1:0]  hdr_used_p,
  output logic [SH_W-1:0]  hdr_used_np,
  output logic [SH_W-1:0]  hdr_used_cpl,
  input  logic             rd_req,
  output logic             rd_gnt,
  input  logic             rd_done,
  output logic [RD_W-1:0]  rd_outstanding,
  output logic [SH_W-1:0]  cpl_reserved
);
  logic [SH_W-1:0]  p_sh_q, np_sh_q, cpl_sh_q;
  logic [RD_W-1:0]  max_rd_q;
  logic [MPS_W-1:0] mps_q;
  logic [SH_W-1:0]  lim  [NUM_CLASS];
  logic [SH_W-1:0]  used [NUM_CLASS];

  hcp_cfg_reg #(.REV3(REV3), .SH_W(SH_W), .RD_W(RD_W), .DEF_MAXRD(DEF_MAXRD)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr),
    .cfg_p_share(cfg_p_share), .cfg_np_share(cfg_np_share), .cfg_cpl_share(cfg_cpl_share),
    .cfg_max_rd(cfg_max_rd), .cfg_mps(cfg_mps), .busy(rd_outstanding != '0),
    .p_sh_q(p_sh_q), .np_sh_q(np_sh_q), .cpl_sh_q(cpl_sh_q),
    .max_rd_q(max_rd_q), .mps_q(mps_q), .err_q(cfg_err)
  );

  assign lim[0] = p_sh_q;
  assign lim[1] = np_sh_q;
  assign lim[2] = cpl_sh_q;

  for (genvar c = 0; c < NUM_CLASS; c++) begin : g_cls
    hcp_class_cnt #(.SH_W(SH_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .arrive(hdr_arrive[c]), .rel(hdr_release[c]),
      .limit(lim[c]), .count(used[c])
    );
  end

  hcp_rd_gate #(.SH_W(SH_W), .RD_W(RD_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .req(rd_req), .done(rd_done), .blk(cfg_wr),
    .max_rd(max_rd_q), .cpl_share(cpl_sh_q), .mps(mps_q),
    .gnt(rd_gnt), .outstanding(rd_outstanding), .reserved(cpl_reserved)
  );

  assign adv_p_hdr    = p_sh_q;
  assign adv_np_hdr   = np_sh_q;
  assign adv_cpl_hdr  = '0;
  assign hdr_used_p   = used[0];
  assign hdr_used_np  = used[1];
  assign hdr_used_cpl = used[2];
endmodule

// File: rtl/hcp_chk.sv
module hcp_chk #(
  parameter int SH_W = 9,
  parameter int RD_W = 6
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cfg_wr,
  input logic            cfg_err,
  input logic [SH_W-1:0] adv_p_hdr,
  input logic [SH_W-1:0] adv_np_hdr,
  input logic [2:0]      hdr_release,
  input logic [SH_W-1:0] hdr_used_p,
  input logic            rd_req,
  input logic            rd_gnt,
  input logic            rd_done,
  input logic [RD_W-1:0] rd_outstanding,
  input logic [SH_W-1:0] cpl_reserved,
  input logic [RD_W-1:0] max_rd_q,
  input logic [SH_W-1:0] cpl_sh_q
);
  assert_gnt_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_gnt |-> (rd_req && !cfg_wr));

  assert_rd_limit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_gnt |-> (rd_outstanding < max_rd_q));

  assert_cpl_fit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cpl_reserved <= cpl_sh_q);

  assert_idle_free_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_outstanding == '0) |-> (cpl_reserved == '0));

  assert_done_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_done && !rd_gnt && rd_outstanding != '0) |=>
      (rd_outstanding == $past(rd_outstanding) - RD_W'(1)));

  assert_reject_keep_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && rd_outstanding != '0) |=>
      (cfg_err && $stable(adv_p_hdr) && $stable(adv_np_hdr)));

  assert_err_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_err) |-> $past(cfg_wr));

  assert_full_ignore_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!hdr_release[0] && hdr_used_p >= adv_p_hdr) |=> $stable(hdr_used_p));
endmodule

bind ib_hdr_credit_part hcp_chk #(.SH_W(SH_W), .RD_W(RD_W)) u_hcp_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_err(cfg_err),
  .adv_p_hdr(adv_p_hdr), .adv_np_hdr(adv_np_hdr), .hdr_release(hdr_release),
  .hdr_used_p(hdr_used_p), .rd_req(rd_req), .rd_gnt(rd_gnt), .rd_done(rd_done),
  .rd_outstanding(rd_outstanding), .cpl_reserved(cpl_reserved),
  .max_rd_q(max_rd_q), .cpl_sh_q(cpl_sh_q)
);

// File: tb/tb_ib_hdr_credit_part.sv
module tb_ib_hdr_credit_part;
  localparam int SH_W = 9;
  localparam int RD_W = 6;
  localparam int TOTAL = 97;

  logic clk = 1'b0;
  logic rst_n;
  logic cfg_wr;
  logic [SH_W-1:0] cfg_p_share, cfg_np_share, cfg_cpl_share;
  logic [RD_W-1:0] cfg_max_rd;
  logic [2:0] cfg_mps;
  logic cfg_err;
  logic [SH_W-1:0] adv_p_hdr, adv_np_hdr, adv_cpl_hdr;
  logic [2:0] hdr_arrive, hdr_release;
  logic [SH_W-1:0] hdr_used_p, hdr_used_np, hdr_used_cpl;
  logic rd_req, rd_gnt, rd_done;
  logic [RD_W-1:0] rd_outstanding;
  logic [SH_W-1:0] cpl_reserved;

  ib_hdr_credit_part dut (.*);

  always #5 clk = ~clk;

  int checks = 0, errors = 0;
  bit finished = 0;
  int m_sh[3], m_used[3];
  int m_max, m_mps, m_err, m_out, m_res;

  function automatic int rsv_of(int code);
    return (128 << code) / 64 + 1;
  endfunction

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic clear_in();
    cfg_wr = 0; hdr_arrive = 0; hdr_release = 0; rd_req = 0; rd_done = 0;
  endtask

  // inputs are set by the caller; evaluates one clock cycle against the model
  task automatic cycle();
    int e_gnt, acc, done_ok, after;
    #3;
    e_gnt = (rd_req && !cfg_wr && m_out < m_max && m_res + rsv_of(m_mps) <= m_sh[2]) ? 1 : 0;
    check("R8/R10", "rd_gnt", int'(rd_gnt), e_gnt);
    done_ok = (rd_done && m_out != 0) ? 1 : 0;
    acc = (cfg_wr && int'(cfg_p_share) + int'(cfg_np_share) + int'(cfg_cpl_share) == TOTAL
           && cfg_mps <= 5 && m_out == 0) ? 1 : 0;
    for (int c = 0; c < 3; c++) begin
      after = m_used[c] - ((hdr_release[c] && m_used[c] != 0) ? 1 : 0);
      if (hdr_arrive[c] && after < m_sh[c]) after++;
      m_used[c] = after;
    end
    m_out = m_out + e_gnt - done_ok;
    m_res = m_res + (e_gnt - done_ok) * rsv_of(m_mps);
    if (cfg_wr) begin
      m_err = acc ? 0 : 1;
      if (acc) begin
        m_sh[0] = cfg_p_share; m_sh[1] = cfg_np_share; m_sh[2] = cfg_cpl_share;
        m_max = cfg_max_rd; m_mps = cfg_mps;
      end
    end
    @(posedge clk);
    #1;
    clear_in();
    check("R3", "cfg_err", int'(cfg_err), m_err);
    check("R2/R4", "adv_p_hdr", int'(adv_p_hdr), m_sh[0]);
    check("R2/R4", "adv_np_hdr", int'(adv_np_hdr), m_sh[1]);
    check("R4", "adv_cpl_hdr", int'(adv_cpl_hdr), 0);
    check("R5/R6", "hdr_used_p", int'(hdr_used_p), m_used[0]);
    check("R5/R6", "hdr_used_np", int'(hdr_used_np), m_used[1]);
    check("R5/R6", "hdr_used_cpl", int'(hdr_used_cpl), m_used[2]);
    check("R9", "rd_outstanding", int'(rd_outstanding), m_out);
    check("R7/R9", "cpl_reserved", int'(cpl_reserved), m_res);
  endtask

  task automatic do_cfg(int p, int np, int cpl, int mx, int mps);
    cfg_wr = 1; cfg_p_share = SH_W'(p); cfg_np_share = SH_W'(np);
    cfg_cpl_share = SH_W'(cpl); cfg_max_rd = RD_W'(mx); cfg_mps = 3'(mps);
    cycle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 0; clear_in();
    cfg_p_share = 0; cfg_np_share = 0; cfg_cpl_share = 0; cfg_max_rd = 0; cfg_mps = 0;
    m_sh[0] = 24; m_sh[1] = 24; m_sh[2] = 49; m_max = 8; m_mps = 0; m_err = 0;
    m_out = 0; m_res = 0;
    for (int c = 0; c < 3; c++) m_used[c] = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset state
    check("R1", "posted share", int'(adv_p_hdr), 24);
    check("R1", "non-posted share", int'(adv_np_hdr), 24);
    check("R1", "cfg_err", int'(cfg_err), 0);
    check("R1", "outstanding", int'(rd_outstanding), 0);
    check("R1", "reserved", int'(cpl_reserved), 0);
    check("R1", "used p", int'(hdr_used_p), 0);

    // R3: sum off by one is rejected
    do_cfg(30, 20, 48, 2, 5);
    check("R3", "kept p share", int'(adv_p_hdr), 24);
    // R2: accepted
    do_cfg(17, 10, 70, 2, 5);
    check("R2", "new p share", int'(adv_p_hdr), 17);
    // R7/R8: one read of 65 fits in 70, a second does not
    rd_req = 1; cycle();
    check("R7", "reserved 4096", int'(cpl_reserved), 65);
    rd_req = 1; cycle();
    check("R8", "second read blocked", int'(rd_outstanding), 1);
    // R3: config while a read is outstanding is rejected
    do_cfg(17, 10, 70, 2, 0);
    check("R3", "busy reject err", int'(cfg_err), 1);
    // R9: release, then done at zero ignored
    rd_done = 1; cycle();
    check("R9", "released", int'(cpl_reserved), 0);
    rd_done = 1; cycle();
    check("R9", "done at zero", int'(rd_outstanding), 0);
    // R8: read limit of 2
    do_cfg(17, 10, 70, 2, 0);
    rd_req = 1; cycle();
    rd_req = 1; cycle();
    rd_req = 1; cycle();
    check("R8", "limit 2", int'(rd_outstanding), 2);
    // R9: grant and done together with room
    rd_done = 1; cycle();
    rd_req = 1; rd_done = 1; cycle();
    check("R9", "net zero", int'(rd_outstanding), 1);
    rd_done = 1; cycle();
    // R10: request during config write is not granted
    rd_req = 1; cfg_wr = 1; cfg_p_share = 17; cfg_np_share = 10; cfg_cpl_share = 70;
    cfg_max_rd = 2; cfg_mps = 0; cycle();
    check("R10", "blocked by cfg", int'(rd_outstanding), 0);
    // R3: invalid payload code
    do_cfg(17, 10, 70, 2, 6);
    check("R3", "mps 6 err", int'(cfg_err), 1);
    // R7: each payload code
    for (int k = 0; k < 6; k++) begin
      do_cfg(16, 16, 65, 4, k);
      rd_req = 1; cycle();
      check("R7", "reservation per code", int'(cpl_reserved), rsv_of(k));
      rd_done = 1; cycle();
    end
    // R5/R6: fill posted class to share, overfill, drain below zero
    do_cfg(3, 4, 90, 4, 0);
    for (int k = 0; k < 5; k++) begin hdr_arrive = 3'b001; cycle(); end
    check("R6", "posted capped", int'(hdr_used_p), 3);
    hdr_arrive = 3'b001; hdr_release = 3'b001; cycle();
    check("R5", "release then arrive", int'(hdr_used_p), 3);
    for (int k = 0; k < 5; k++) begin hdr_release = 3'b001; cycle(); end
    check("R6", "release at zero", int'(hdr_used_p), 0);

    // random mix
    for (int n = 0; n < 3000; n++) begin
      if ($urandom % 40 == 0) begin
        int cpl, p;
        cpl = 10 + $urandom % 80;
        p = $urandom % (TOTAL - cpl + 1);
        cfg_wr = 1; cfg_cpl_share = SH_W'(cpl); cfg_p_share = SH_W'(p);
        cfg_np_share = SH_W'(TOTAL - cpl - p + (($urandom % 4 == 0) ? 1 : 0));
        cfg_max_rd = RD_W'($urandom % 8); cfg_mps = 3'($urandom % 7);
      end
      hdr_arrive = 3'($urandom); hdr_release = 3'($urandom);
      rd_req = ($urandom % 2) == 0;
      rd_done = ($urandom % 3) == 0;
      cycle();
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule